// File: doc/BRIEF.md
# Butterfly Multiply-Accumulate Rounding Unit

This datapath computes one step of the accumulate form of a butterfly. It takes two signed accumulators, `t` and `s`, an operand `a`, a coefficient `b` and a shift amount `n`. It forms the signed product `a*b` once. That product is added to `t` and, in the same cycle, subtracted from `s`. When `n` is nonzero, both accumulated values are rounded to nearest by adding `2^(n-1)`. They are then shifted right arithmetically by `n`. The rounding and the shift act on the accumulated sums, not on the product alone.

The datapath width is set by the parameter `XLEN`. The width of the accumulation path depends on that parameter:

- When `XLEN` is 64, accumulation and rounding wrap within `XLEN` bits. Only the low half of the product is used.
- For any other width, accumulation runs at `2*XLEN` bits with sign-extended accumulators, so no intermediate value wraps.

The results are registered with one cycle of latency. A two-state controller, built on an enumerated state register, tracks whether the output register holds a fresh result:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | The output register holds no new result. |
| `ST_EMIT` | A new result is on the outputs this cycle. |

| Transition | From | To | Condition |
|------------|------|----|-----------|
| `GO_EMIT` | either state | `ST_EMIT` | `in_valid` high at the clock edge |
| `GO_IDLE` | either state | `ST_IDLE` | `in_valid` low at the clock edge |

Top module: `bmr_unit`

## Requirements
- R1: The product is the signed two's-complement product of `a_in` and `b_in`, formed at `2*XLEN` bits.
- R2: When `shamt` is 0, no rounding is applied: `t_out = t_in + low(product)` and `s_out = s_in - low(product)`, both modulo `2^XLEN`. As a result, `t_out + s_out` equals `t_in + s_in` modulo `2^XLEN`.
- R3: When `shamt` is nonzero, the same positive constant `2^(shamt-1)` is added to both accumulated values before the shift. It is not negated for the subtracting lane.
- R4: When `XLEN` is not 64, `t_in` and `s_in` are sign-extended to `2*XLEN` bits and combined with the full product. Each output is bits `[shamt+XLEN-1 : shamt]` of the rounded double-width value, so a sum that passes `2^(XLEN-1)` does not wrap.
- R5: When `XLEN` is 64, accumulation and rounding wrap within 64 bits using the low half of the product. The vacated upper `shamt` bits of each output are filled with bit 63 of that lane's rounded value.
- R6: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `t_out` and `s_out` load only on such cycles and hold their value otherwise.
- R7: While `rst_n` is low, `out_valid`, `t_out` and `s_out` are 0.
- R8: `shamt` is `$clog2(XLEN)` bits wide and is unsigned, so it covers every shift from 0 to `XLEN-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are presented this cycle |
| t_in | input | XLEN | Accumulator for the adding lane (signed) |
| s_in | input | XLEN | Accumulator for the subtracting lane (signed) |
| a_in | input | XLEN | Operand (signed) |
| b_in | input | XLEN | Coefficient (signed) |
| shamt | input | $clog2(XLEN) | Rounding shift amount |
| out_valid | output | 1 | Results are fresh this cycle |
| t_out | output | XLEN | Rounded, shifted sum |
| s_out | output | XLEN | Rounded, shifted difference |

## Verification
The assertions check on every cycle:

- The valid timing.
- That the output register holds its value between accepted operations.
- The reset values.
- That, for a zero shift, the two outputs always sum to the two input accumulators.

The actual arithmetic can only be shown by the bench's scenarios:

- The sign of the product.
- The placement of the rounding constant and the carry it causes across the shift boundary.
- The absence of wrap in the double-width path.
- The wrap and sign fill in the 64-bit path.

For this reason, the bench runs a second instance with `XLEN` set to 64.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

    // Output-register controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } bmr_state_e;

endpackage

// File: rtl/bmr_mul.sv
// Signed full-width multiplier for the butterfly product.
module bmr_mul #(
    parameter int XLEN = 32,
    localparam int PW = 2 * XLEN
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [PW-1:0]   prod
);

    logic signed [XLEN-1:0] sa;
    logic signed [XLEN-1:0] sb;
    logic signed [PW-1:0]   sp;

    always_comb begin
        sa = opa;
        sb = opb;
        sp = PW'(sa) * PW'(sb);
    end

    assign prod = sp;

endmodule

// File: rtl/bmr_accum.sv
// Adds the product to one accumulator, subtracts it from the other, and
// applies the common rounding constant. ACCW picks wrap or double width.
module bmr_accum #(
    parameter int XLEN = 32,
    parameter int ACCW = 64,
    localparam int NW  = $clog2(XLEN),
    localparam int PW  = 2 * XLEN
) (
    input  logic [XLEN-1:0] acc_t,
    input  logic [XLEN-1:0] acc_s,
    input  logic [PW-1:0]   prod,
    input  logic [NW-1:0]   n,
    output logic [ACCW-1:0] sum,
    output logic [ACCW-1:0] dif
);

    logic [ACCW-1:0] t_ext;
    logic [ACCW-1:0] s_ext;
    logic [ACCW-1:0] p_ext;
    logic [ACCW-1:0] rc;
    logic [NW-1:0]   nm1;

    generate
        if (ACCW == PW) begin : g_wide
            always_comb begin
                t_ext = {{XLEN{acc_t[XLEN-1]}}, acc_t};
                s_ext = {{XLEN{acc_s[XLEN-1]}}, acc_s};
                p_ext = prod;
            end
        end else begin : g_wrap
            always_comb begin
                t_ext = acc_t;
                s_ext = acc_s;
                p_ext = prod[ACCW-1:0];
            end
        end
    endgenerate

    always_comb begin
        nm1 = n - NW'(1);
        if (n != '0) begin
            rc = ACCW'(1) << nm1;
        end else begin
            rc = '0;
        end
        sum = t_ext + p_ext + rc;
        dif = s_ext - p_ext + rc;
    end

endmodule

// File: rtl/bmr_shift.sv
// Arithmetic right shift of one rounded lane, keeping XLEN result bits.
module bmr_shift #(
    parameter int XLEN = 32,
    parameter int ACCW = 64,
    localparam int NW  = $clog2(XLEN)
) (
    input  logic [ACCW-1:0] val,
    input  logic [NW-1:0]   n,
    output logic [XLEN-1:0] res
);

    logic signed [ACCW-1:0] sv;
    logic signed [ACCW-1:0] sh;

    always_comb begin
        sv  = val;
        sh  = sv >>> n;
        res = sh[XLEN-1:0];
    end

endmodule

// File: rtl/bmr_unit.sv
// Butterfly multiply-accumulate with rounding shift, one cycle latency.
module bmr_unit
    import bmr_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int NW   = $clog2(XLEN),
    localparam int PW   = 2 * XLEN,
    localparam bit WIDE = (XLEN != 64),
    localparam int ACCW = WIDE ? PW : XLEN,
    localparam int LANES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] t_in,
    input  logic [XLEN-1:0] s_in,
    input  logic [XLEN-1:0] a_in,
    input  logic [XLEN-1:0] b_in,
    input  logic [NW-1:0]   shamt,
    output logic            out_valid,
    output logic [XLEN-1:0] t_out,
    output logic [XLEN-1:0] s_out
);

    bmr_state_e st_q, st_d;

    logic [PW-1:0]   prod;
    logic [ACCW-1:0] acc   [LANES];
    logic [XLEN-1:0] lane_r[LANES];
    logic [XLEN-1:0] t_q, s_q;

    bmr_mul #(.XLEN(XLEN)) u_mul (
        .opa  (a_in),
        .opb  (b_in),
        .prod (prod)
    );

    bmr_accum #(.XLEN(XLEN), .ACCW(ACCW)) u_acc (
        .acc_t (t_in),
        .acc_s (s_in),
        .prod  (prod),
        .n     (shamt),
        .sum   (acc[0]),
        .dif   (acc[1])
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            bmr_shift #(.XLEN(XLEN), .ACCW(ACCW)) u_shift (
                .val (acc[g]),
                .n   (shamt),
                .res (lane_r[g])
            );
        end
    endgenerate

    // Next-state logic: transitions GO_EMIT and GO_IDLE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_d = in_valid ? ST_EMIT : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
            s_q <= '0;
        end else if (in_valid) begin
            t_q <= lane_r[0];
            s_q <= lane_r[1];
        end
    end

    assign out_valid = (st_q == ST_EMIT);
    assign t_out     = t_q;
    assign s_out     = s_q;

endmodule

// File: rtl/bmr_unit_chk.sv
// Protocol and invariant checks for bmr_unit.
module bmr_unit_chk #(
    parameter int XLEN = 32,
    localparam int NW  = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] t_in,
    input logic [XLEN-1:0] s_in,
    input logic [NW-1:0]   shamt,
    input logic            out_valid,
    input logic [XLEN-1:0] t_out,
    input logic [XLEN-1:0] s_out
);

    logic [XLEN-1:0] in_total;
    logic [XLEN-1:0] out_total;

    always_comb begin
        in_total  = t_in + s_in;
        out_total = t_out + s_out;
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(t_out) && $stable(s_out))); // R6

    AST_ZERO_SHIFT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shamt == '0) |=> (out_total == $past(in_total))); // R2

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (!out_valid && t_out == '0 && s_out == '0); // R7
        end
    end

endmodule

bind bmr_unit bmr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .t_in      (t_in),
    .s_in      (s_in),
    .shamt     (shamt),
    .out_valid (out_valid),
    .t_out     (t_out),
    .s_out     (s_out)
);

// File: tb/bmr_unit_tb.sv
module bmr_unit_tb;

    typedef struct packed {
        logic [31:0] t;
        logic [31:0] s;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  n;
        logic [31:0] et;
        logic [31:0] es;
    } vec_t;

    // R1 R2 R3 R4 R8: hand-computed expected values for XLEN = 32
    localparam int NVEC = 8;
    localparam vec_t VEC[NVEC] = '{
        '{32'd10,       32'd20,       32'd3,          32'd4, 5'd0,  32'd22,       32'd8},
        '{32'd0,        32'd0,        32'hFFFFFFFF,   32'd5, 5'd0,  32'hFFFFFFFB, 32'd5},
        '{32'd1,        32'd1,        32'd1,          32'd1, 5'd1,  32'd1,        32'd0},
        '{32'hFFFFFFFD, 32'd0,        32'd0,          32'd0, 5'd1,  32'hFFFFFFFF, 32'd0},
        '{32'd4,        32'd3,        32'd0,          32'd0, 5'd3,  32'd1,        32'd0},
        '{32'd0,        32'd0,        32'h40000000,   32'd4, 5'd4,  32'h10000000, 32'hF0000000},
        '{32'h7FFFFFFF, 32'h80000000, 32'd0,          32'd0, 5'd31, 32'd1,        32'hFFFFFFFF},
        '{32'd100,      32'hFFFFFF9C, 32'hFFFFFFF9,   32'd9, 5'd2,  32'd9,        32'hFFFFFFF7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] t_in = '0, s_in = '0, a_in = '0, b_in = '0;
    logic [4:0]  shamt = '0;
    logic        out_valid;
    logic [31:0] t_out, s_out;

    logic        v64 = 1'b0;
    logic [63:0] t64 = '0, s64 = '0, a64 = '0, b64 = '0;
    logic [5:0]  n64 = '0;
    logic        ov64;
    logic [63:0] to64, so64;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bmr_unit #(.XLEN(32)) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .t_in (t_in), .s_in (s_in), .a_in (a_in), .b_in (b_in), .shamt (shamt),
        .out_valid (out_valid), .t_out (t_out), .s_out (s_out)
    );

    bmr_unit #(.XLEN(64)) u_dut64 (
        .clk (clk), .rst_n (rst_n), .in_valid (v64),
        .t_in (t64), .s_in (s64), .a_in (a64), .b_in (b64), .shamt (n64),
        .out_valid (ov64), .t_out (to64), .s_out (so64)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic run32(input logic [31:0] t, input logic [31:0] s, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] n);
        @(negedge clk);
        t_in = t; s_in = s; a_in = a; b_in = b; shamt = n; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run64(input logic [63:0] t, input logic [63:0] s, input logic [63:0] a,
                         input logic [63:0] b, input logic [5:0] n);
        @(negedge clk);
        t64 = t; s64 = s; a64 = a; b64 = b; n64 = n; v64 = 1'b1;
        @(negedge clk);
        v64 = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        repeat (2) @(negedge clk);
        check("R7 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R7 t_out in reset", {32'd0, t_out}, 64'd0);
        check("R7 s_out in reset", {32'd0, s_out}, 64'd0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R8
        for (int i = 0; i < NVEC; i++) begin
            run32(VEC[i].t, VEC[i].s, VEC[i].a, VEC[i].b, VEC[i].n);
            check($sformatf("R6 valid vec %0d", i), {63'd0, out_valid}, 64'd1);
            check($sformatf("R1 R2 R3 R4 R8 t_out vec %0d", i), {32'd0, t_out}, {32'd0, VEC[i].et});
            check($sformatf("R1 R2 R3 R4 R8 s_out vec %0d", i), {32'd0, s_out}, {32'd0, VEC[i].es});
        end

        // R6: no valid input -> outputs hold, out_valid low
        @(negedge clk);
        t_in = 32'h12345678; s_in = 32'h9ABCDEF0; a_in = 32'd7; b_in = 32'd7; shamt = 5'd0;
        @(negedge clk);
        check("R6 out_valid low when idle", {63'd0, out_valid}, 64'd0);
        check("R6 t_out held", {32'd0, t_out}, 64'd9);
        check("R6 s_out held", {32'd0, s_out}, {32'd0, 32'hFFFFFFF7});

        // R4: sum crosses 2^31 without wrapping in the double-width path
        run32(32'h7FFFFFFF, 32'd0, 32'd0, 32'd0, 5'd1);
        check("R4 no wrap t_out", {32'd0, t_out}, {32'd0, 32'h40000000});
        check("R3 rounding on s lane", {32'd0, s_out}, 64'd0);

        // R3: same positive constant on the subtracting lane (s - p = 6, +2 = 8, >>2 = 2)
        run32(32'd0, 32'd7, 32'd1, 32'd1, 5'd2);
        check("R3 t lane round", {32'd0, t_out}, 64'd0);
        check("R3 s lane positive constant", {32'd0, s_out}, 64'd2);

        // R5: 64-bit wrap and sign fill from the rounded value
        run64(64'h7FFFFFFFFFFFFFFF, 64'd0, 64'd0, 64'd0, 6'd1);
        check("R5 valid 64", {63'd0, ov64}, 64'd1);
        check("R5 wrap then sign fill", to64, 64'hC000000000000000);
        check("R5 s lane 64", so64, 64'd0);

        // R5: only the low half of the product is used
        run64(64'd5, 64'd5, 64'h0000000100000000, 64'h0000000100000000, 6'd0);
        check("R5 low product t", to64, 64'd5);
        check("R5 low product s", so64, 64'd5);

        // R2 R5: negative product at 64 bits, zero shift
        run64(64'd0, 64'd0, 64'hFFFFFFFFFFFFFFFF, 64'd3, 6'd0);
        check("R2 R5 t neg product", to64, 64'hFFFFFFFFFFFFFFFD);
        check("R2 R5 s neg product", so64, 64'd3);

        // R7: reset clears outputs after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 t_out cleared", {32'd0, t_out}, 64'd0);
        check("R7 valid cleared", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule